// File: doc/BRIEF.md
# TCP Session State Tracker

This block is the connection-tracking core of a stateful packet filter. A header parser upstream presents one TCP segment at a time as separate fields: both IP addresses, both ports, the control flags, the sequence number, the acknowledgment number and the advertised window. The block searches a small on-chip session table for that connection and walks the session through the TCP handshake. It then returns a single accept-or-drop verdict. A new session can only start with a bare SYN. Data passes only after the full three-way handshake, and only while its sequence number stays inside the window the peer advertised.

Every live entry holds a countdown timer that steps on a shared tick pulse. The reload value depends on the state: a handshake timeout for half-open sessions, an idle timeout for open sessions, and a linger time once both sides have sent FIN. When a timer runs out, the entry is freed. The search visits one entry per clock, so the packet interface uses a valid/busy handshake and delivers each verdict as a one-cycle result strobe.

Top module: `tcp_sess_tracker`

## Requirements
- R1: When no entry matches, a bare SYN is accepted and opens an entry in the half-open state. Flag encoding is bit0 FIN, bit1 SYN, bit2 RST, bit3 ACK; a bare SYN has SYN set and the other three clear. Any other packet with no match is dropped.
- R2: A bare SYN that finds no match and no free entry is dropped. The table holds N_ENT entries.
- R3: In the half-open state, the only packet accepted is one from the responder with SYN and ACK set, FIN and RST clear, and an acknowledgment number equal to the initiator's sequence number plus one. The responder's packet has source and destination swapped relative to the SYN. Anything else, including initiator data, is dropped and leaves the entry unchanged.
- R4: After the SYN-ACK, an initiator packet is accepted and the session becomes established when it meets all of these: ACK set, SYN/FIN/RST clear, acknowledgment equal to the responder's sequence number plus one, and in window. From then on, in-window data from either side is accepted.
- R5: An established packet is in window when (its sequence − the last accepted sequence from the same side) mod 2^32 ≤ the window last advertised by the other side. Packets outside the window are dropped and change nothing. Packets inside are accepted and update that side's last sequence and window.
- R6: An in-window RST on a known session is accepted and frees the entry at once. An out-of-window RST is dropped and the entry stays.
- R7: A FIN from one side followed by a FIN from the other side puts the session into linger, loaded with the linger timeout. Packets accepted during linger do not reload the timer, and the entry is freed on the tick that ends the timeout.
- R8: A half-open entry is freed after the handshake timeout in ticks, counted from its last accepted packet. It survives one tick fewer than the timeout.
- R9: An open entry is freed after the idle timeout in ticks with no accepted packet. Each accepted packet reloads the timer.
- R10: pkt_busy is high from the cycle after a packet is taken until the cycle its result appears. res_valid pulses exactly once for each packet taken, with pkt_busy low.
- R11: A SYN that matches an existing entry is dropped.
- R12: After reset the table is empty and pkt_busy and res_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Aging pulse; each pulse steps all live timers |
| cfg_hs_to | input | TMR_W | Handshake timeout in ticks |
| cfg_idle_to | input | TMR_W | Idle timeout in ticks |
| cfg_fin_to | input | TMR_W | Linger timeout in ticks |
| pkt_valid | input | 1 | Packet fields valid; taken when pkt_busy is low |
| pkt_busy | output | 1 | A packet is being looked up |
| pkt_src_ip | input | 32 | Source IP address |
| pkt_dst_ip | input | 32 | Destination IP address |
| pkt_src_port | input | 16 | Source TCP port |
| pkt_dst_port | input | 16 | Destination TCP port |
| pkt_flags | input | 4 | {ACK, RST, SYN, FIN} |
| pkt_seq | input | 32 | Sequence number |
| pkt_ack | input | 32 | Acknowledgment number |
| pkt_win | input | 16 | Advertised window |
| res_valid | output | 1 | Verdict strobe |
| res_accept | output | 1 | 1 = accept, 0 = drop |

## Verification
The bench targets these handshake corner cases:
- a SYN-ACK whose acknowledgment is off by one;
- initiator data sent before the handshake completes;
- a duplicate SYN.

A design that skipped any of these checks would open sessions that a spoofer could forge. For the window, the bench places sequence numbers exactly at the limit, one past it, and just behind the last value. It also runs a session whose numbers wrap past 2^32, where a plain unsigned compare would reject good traffic or accept stale data. Timers are probed one tick before and at their expiry, in half-open, idle and linger states, to catch off-by-one aging and linger reloads that would keep a closed session alive. A full table is also exercised, to check that a SYN with no free slot is refused and overwrites nothing.

// File: rtl/tcp_trk_pkg.sv
package tcp_trk_pkg;
  parameter int unsigned TMR_W = 16;

  localparam int unsigned FL_FIN = 0;
  localparam int unsigned FL_SYN = 1;
  localparam int unsigned FL_RST = 2;
  localparam int unsigned FL_ACK = 3;

  typedef enum logic [2:0] {
    ST_FREE   = 3'd0,
    ST_SYN    = 3'd1,
    ST_SYNACK = 3'd2,
    ST_OPEN   = 3'd3,
    ST_FIN1   = 3'd4,
    ST_LINGER = 3'd5
  } sess_st_e;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [3:0]  flags;
    logic [31:0] seq;
    logic [31:0] ack;
    logic [15:0] win;
  } pkt_t;

  // side "i" = initiator (sender of the opening SYN), side "r" = responder
  typedef struct packed {
    sess_st_e         state;
    logic [31:0]      ip_i;
    logic [31:0]      ip_r;
    logic [15:0]      port_i;
    logic [15:0]      port_r;
    logic [31:0]      seq_i;
    logic [31:0]      seq_r;
    logic [15:0]      win_i;
    logic [15:0]      win_r;
    logic             fin_r;
    logic [TMR_W-1:0] tmr;
  } ent_t;

  function automatic logic [TMR_W-1:0] tmr_load(input logic [TMR_W-1:0] t);
    return (t == '0) ? TMR_W'(1) : t;
  endfunction
endpackage

// File: rtl/trk_win_chk.sv
module trk_win_chk #(
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned WIN_W = 16
) (
  input  logic [SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0] last,
  input  logic [WIN_W-1:0] win,
  output logic             ok
);
  logic [SEQ_W-1:0] off;

  // modulo-2^SEQ_W distance ahead of the last accepted value
  always_comb begin
    off = seq - last;
    ok  = (off <= SEQ_W'(win));
  end
endmodule

// File: rtl/trk_step.sv
module trk_step
  import tcp_trk_pkg::*;
(
  input  logic             hit,
  input  logic             rev,
  input  logic             free_ok,
  input  ent_t             cur,
  input  pkt_t             pk,
  input  logic [TMR_W-1:0] hs_to,
  input  logic [TMR_W-1:0] idle_to,
  input  logic [TMR_W-1:0] fin_to,
  output logic             accept,
  output logic             wr,
  output ent_t             nxt
);
  logic f_fin, f_syn, f_rst, f_ack, bare_syn, in_win;
  logic [31:0] own_last;
  logic [15:0] peer_win;

  assign f_fin    = pk.flags[FL_FIN];
  assign f_syn    = pk.flags[FL_SYN];
  assign f_rst    = pk.flags[FL_RST];
  assign f_ack    = pk.flags[FL_ACK];
  assign bare_syn = f_syn & ~f_ack & ~f_fin & ~f_rst;
  assign own_last = rev ? cur.seq_r : cur.seq_i;
  assign peer_win = rev ? cur.win_i : cur.win_r;

  trk_win_chk #(.SEQ_W(32), .WIN_W(16)) u_win (
    .seq (pk.seq),
    .last(own_last),
    .win (peer_win),
    .ok  (in_win)
  );

  always_comb begin
    nxt    = cur;
    accept = 1'b0;
    wr     = 1'b0;
    if (!hit) begin
      if (bare_syn && free_ok) begin
        accept     = 1'b1;
        wr         = 1'b1;
        nxt.state  = ST_SYN;
        nxt.ip_i   = pk.src;
        nxt.ip_r   = pk.dst;
        nxt.port_i = pk.sport;
        nxt.port_r = pk.dport;
        nxt.seq_i  = pk.seq;
        nxt.win_i  = pk.win;
        nxt.seq_r  = '0;
        nxt.win_r  = '0;
        nxt.fin_r  = 1'b0;
        nxt.tmr    = tmr_load(hs_to);
      end
    end else begin
      unique case (cur.state)
        ST_SYN: begin
          if (rev && f_syn && f_ack && !f_fin && !f_rst && pk.ack == cur.seq_i + 32'd1) begin
            accept    = 1'b1;
            wr        = 1'b1;
            nxt.state = ST_SYNACK;
            nxt.seq_r = pk.seq;
            nxt.win_r = pk.win;
            nxt.tmr   = tmr_load(hs_to);
          end
        end
        ST_SYNACK: begin
          if (!rev && f_ack && !f_syn && !f_fin && !f_rst && in_win &&
              pk.ack == cur.seq_r + 32'd1) begin
            accept    = 1'b1;
            wr        = 1'b1;
            nxt.state = ST_OPEN;
            nxt.seq_i = pk.seq;
            nxt.win_i = pk.win;
            nxt.tmr   = tmr_load(idle_to);
          end else if (f_rst && !f_syn && in_win) begin
            accept    = 1'b1;
            wr        = 1'b1;
            nxt.state = ST_FREE;
          end
        end
        ST_OPEN, ST_FIN1, ST_LINGER: begin
          if (!f_syn && in_win) begin
            accept = 1'b1;
            wr     = 1'b1;
            if (rev) begin
              nxt.seq_r = pk.seq;
              nxt.win_r = pk.win;
            end else begin
              nxt.seq_i = pk.seq;
              nxt.win_i = pk.win;
            end
            if (f_rst) begin
              nxt.state = ST_FREE;
            end else if (cur.state == ST_OPEN && f_fin) begin
              nxt.state = ST_FIN1;
              nxt.fin_r = rev;
              nxt.tmr   = tmr_load(idle_to);
            end else if (cur.state == ST_FIN1 && f_fin && rev != cur.fin_r) begin
              nxt.state = ST_LINGER;
              nxt.tmr   = tmr_load(fin_to);
            end else if (cur.state != ST_LINGER) begin
              nxt.tmr   = tmr_load(idle_to);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcp_sess_tracker.sv
module tcp_sess_tracker
  import tcp_trk_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [TMR_W-1:0] cfg_hs_to,
  input  logic [TMR_W-1:0] cfg_idle_to,
  input  logic [TMR_W-1:0] cfg_fin_to,
  input  logic             pkt_valid,
  output logic             pkt_busy,
  input  logic [31:0]      pkt_src_ip,
  input  logic [31:0]      pkt_dst_ip,
  input  logic [15:0]      pkt_src_port,
  input  logic [15:0]      pkt_dst_port,
  input  logic [3:0]       pkt_flags,
  input  logic [31:0]      pkt_seq,
  input  logic [31:0]      pkt_ack,
  input  logic [15:0]      pkt_win,
  output logic             res_valid,
  output logic             res_accept
);
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_DECIDE} scan_e;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  assign rst_q = rst_sync[1];

  scan_e            fsm, fsm_n;
  logic [IDX_W-1:0] idx, idx_n, hit_idx, hit_idx_n, free_idx, free_idx_n, wr_idx;
  logic             hit_f, hit_f_n, hit_rev, hit_rev_n, free_f, free_f_n;
  pkt_t             pk, pk_n, pk_in;
  ent_t             tab [N_ENT];
  ent_t             scan_ent, cur_ent, nxt_ent;
  logic             scan_live, m_fwd, m_bwd, step_hit, step_acc, step_wr, dec_wr;

  assign pk_in = '{src: pkt_src_ip, dst: pkt_dst_ip, sport: pkt_src_port,
                   dport: pkt_dst_port, flags: pkt_flags, seq: pkt_seq,
                   ack: pkt_ack, win: pkt_win};

  assign scan_ent  = tab[idx];
  assign scan_live = (scan_ent.state != ST_FREE);
  assign m_fwd = scan_ent.ip_i == pk.src && scan_ent.ip_r == pk.dst &&
                 scan_ent.port_i == pk.sport && scan_ent.port_r == pk.dport;
  assign m_bwd = scan_ent.ip_i == pk.dst && scan_ent.ip_r == pk.src &&
                 scan_ent.port_i == pk.dport && scan_ent.port_r == pk.sport;

  assign cur_ent  = tab[hit_f ? hit_idx : free_idx];
  assign step_hit = hit_f && (cur_ent.state != ST_FREE);
  assign wr_idx   = step_hit ? hit_idx : free_idx;
  assign dec_wr   = (fsm == SC_DECIDE) && step_wr;
  assign pkt_busy = (fsm != SC_IDLE);

  trk_step u_step (
    .hit    (step_hit),
    .rev    (hit_rev),
    .free_ok(free_f),
    .cur    (cur_ent),
    .pk     (pk),
    .hs_to  (cfg_hs_to),
    .idle_to(cfg_idle_to),
    .fin_to (cfg_fin_to),
    .accept (step_acc),
    .wr     (step_wr),
    .nxt    (nxt_ent)
  );

  // next-state logic of the search sequencer
  always_comb begin
    fsm_n      = fsm;
    idx_n      = idx;
    hit_f_n    = hit_f;
    hit_idx_n  = hit_idx;
    hit_rev_n  = hit_rev;
    free_f_n   = free_f;
    free_idx_n = free_idx;
    pk_n       = pk;
    unique case (fsm)
      SC_IDLE: if (pkt_valid) begin
        pk_n     = pk_in;
        idx_n    = '0;
        hit_f_n  = 1'b0;
        free_f_n = 1'b0;
        fsm_n    = SC_SCAN;
      end
      SC_SCAN: begin
        if (scan_live && (m_fwd || m_bwd)) begin
          hit_f_n   = 1'b1;
          hit_idx_n = idx;
          hit_rev_n = !m_fwd;
          fsm_n     = SC_DECIDE;
        end else begin
          if (!scan_live && !free_f) begin
            free_f_n   = 1'b1;
            free_idx_n = idx;
          end
          if (idx == LAST_IDX) fsm_n = SC_DECIDE;
          else                 idx_n = idx + IDX_W'(1);
        end
      end
      default: fsm_n = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fsm        <= SC_IDLE;
      idx        <= '0;
      hit_f      <= 1'b0;
      hit_idx    <= '0;
      hit_rev    <= 1'b0;
      free_f     <= 1'b0;
      free_idx   <= '0;
      pk         <= '0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      fsm        <= fsm_n;
      idx        <= idx_n;
      hit_f      <= hit_f_n;
      hit_idx    <= hit_idx_n;
      hit_rev    <= hit_rev_n;
      free_f     <= free_f_n;
      free_idx   <= free_idx_n;
      pk         <= pk_n;
      res_valid  <= (fsm == SC_DECIDE);
      res_accept <= (fsm == SC_DECIDE) && step_acc;
    end
  end

  // session table: a packet write wins over aging in the same cycle
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < N_ENT; i++) tab[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (dec_wr && wr_idx == IDX_W'(i)) begin
          tab[i] <= nxt_ent;
        end else if (tick && tab[i].state != ST_FREE) begin
          if (tab[i].tmr <= TMR_W'(1)) tab[i].state <= ST_FREE;
          else                         tab[i].tmr   <= tab[i].tmr - TMR_W'(1);
        end
      end
    end
  end

  // R10: a verdict follows a busy cycle and coincides with busy low
  p_result_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_q)
    res_valid |-> ($past(pkt_busy) && !pkt_busy));

  // R1: an entry is only opened by a bare SYN with no live match
  p_open_on_syn_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_wr && !step_hit) |-> (pk.flags == 4'b0010));

  // R4: the open state is reached only from the SYN-ACK-seen state
  p_open_via_handshake_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_wr && nxt_ent.state == ST_OPEN) |->
      (step_hit && (cur_ent.state == ST_SYNACK || cur_ent.state == ST_OPEN)));

  // R2: a newly opened entry never lands on a live slot
  p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_wr && !step_hit) |-> (tab[free_idx].state == ST_FREE));

  // R8: every live entry carries a running timer
  for (genvar g = 0; g < N_ENT; g++) begin : g_tmr_chk
    p_live_timer_r8: assert property (@(posedge clk) disable iff (!rst_q)
      (tab[g].state != ST_FREE) |-> (tab[g].tmr != '0));
  end
endmodule

// File: tb/tcp_sess_tracker_bench.sv
module tcp_sess_tracker_bench;
  import tcp_trk_pkg::*;

  localparam logic [3:0] F_FIN = 4'b0001;
  localparam logic [3:0] F_SYN = 4'b0010;
  localparam logic [3:0] F_RST = 4'b0100;
  localparam logic [3:0] F_ACK = 4'b1000;
  localparam logic [31:0] IP_A = 32'h0a00_0001;
  localparam logic [31:0] IP_B = 32'hc0a8_0002;
  localparam logic [15:0] PT_A = 16'd1234;
  localparam logic [15:0] PT_B = 16'd80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [TMR_W-1:0] cfg_hs_to = TMR_W'(3);
  logic [TMR_W-1:0] cfg_idle_to = TMR_W'(5);
  logic [TMR_W-1:0] cfg_fin_to = TMR_W'(2);
  logic pkt_valid = 1'b0;
  logic pkt_busy;
  logic [31:0] pkt_src_ip = '0, pkt_dst_ip = '0, pkt_seq = '0, pkt_ack = '0;
  logic [15:0] pkt_src_port = '0, pkt_dst_port = '0, pkt_win = '0;
  logic [3:0]  pkt_flags = '0;
  logic res_valid, res_accept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  bit e_pop;
  string t_pop;

  always #2.5 clk = ~clk;

  tcp_sess_tracker u_tcp_sess_tracker (
    .clk, .rst_n, .tick, .cfg_hs_to, .cfg_idle_to, .cfg_fin_to,
    .pkt_valid, .pkt_busy, .pkt_src_ip, .pkt_dst_ip, .pkt_src_port,
    .pkt_dst_port, .pkt_flags, .pkt_seq, .pkt_ack, .pkt_win,
    .res_valid, .res_accept
  );

  // monitor: pops the scoreboard on every verdict
  always @(negedge clk) begin
    if (res_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected verdict actual=%0b expected=none", res_accept);
      end else begin
        e_pop = exp_q.pop_front();
        t_pop = tag_q.pop_front();
        if (res_accept !== e_pop) begin
          errors++;
          $display("FAIL %s verdict actual=%0b expected=%0b", t_pop, res_accept, e_pop);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [15:0] sp,
                      input logic [15:0] dp, input logic [3:0] fl, input logic [31:0] sq,
                      input logic [31:0] ak, input logic [15:0] w, input bit exp,
                      input string tag);
    @(negedge clk);
    while (pkt_busy) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    pkt_src_ip = s; pkt_dst_ip = d; pkt_src_port = sp; pkt_dst_port = dp;
    pkt_flags = fl; pkt_seq = sq; pkt_ack = ak; pkt_win = w;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(pkt_busy === 1'b1, "R10 busy after take", int'(pkt_busy), 1);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic ini(input logic [3:0] fl, input logic [31:0] sq, input logic [31:0] ak,
                     input logic [15:0] w, input bit exp, input string tag);
    send(IP_A, IP_B, PT_A, PT_B, fl, sq, ak, w, exp, tag);
  endtask

  task automatic rsp(input logic [3:0] fl, input logic [31:0] sq, input logic [31:0] ak,
                     input logic [15:0] w, input bit exp, input string tag);
    send(IP_B, IP_A, PT_B, PT_A, fl, sq, ak, w, exp, tag);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(pkt_busy === 1'b0, "R12 busy after reset", int'(pkt_busy), 0);
    chk(res_valid === 1'b0, "R12 res_valid after reset", int'(res_valid), 0);
    ini(F_ACK, 32'd1, 32'd0, 16'd100, 1'b0, "R12 empty table drops ACK");

    // handshake and window
    ini(F_ACK, 32'd1000, 32'd0, 16'd500, 1'b0, "R1 miss non-SYN");
    ini(F_SYN, 32'd1000, 32'd0, 16'd500, 1'b1, "R1 bare SYN opens");
    ini(F_SYN, 32'd1000, 32'd0, 16'd500, 1'b0, "R11 duplicate SYN");
    ini(F_ACK, 32'd1001, 32'd0, 16'd500, 1'b0, "R3 data before SYN-ACK");
    rsp(F_SYN | F_ACK, 32'd5000, 32'd1000, 16'd800, 1'b0, "R3 SYN-ACK bad ack");
    rsp(F_SYN | F_ACK, 32'd5000, 32'd1001, 16'd800, 1'b1, "R3 SYN-ACK good");
    ini(F_ACK, 32'd1001, 32'd5000, 16'd600, 1'b0, "R4 final ACK bad ack");
    ini(F_ACK, 32'd1001, 32'd5001, 16'd600, 1'b1, "R4 final ACK");
    ini(F_ACK, 32'd1801, 32'd5001, 16'd600, 1'b1, "R5 at window edge");
    ini(F_ACK, 32'd2602, 32'd5001, 16'd600, 1'b0, "R5 one past edge");
    ini(F_ACK, 32'd2600, 32'd5001, 16'd600, 1'b1, "R5 inside window");
    rsp(F_ACK, 32'd5600, 32'd2600, 16'd800, 1'b1, "R4 responder data");
    rsp(F_ACK, 32'd5599, 32'd2600, 16'd800, 1'b0, "R5 behind last seq");
    ini(F_RST, 32'd3500, 32'd0, 16'd0, 1'b0, "R6 RST out of window");
    ini(F_ACK, 32'd2600, 32'd5600, 16'd600, 1'b1, "R6 entry kept");
    ini(F_RST, 32'd2600, 32'd0, 16'd0, 1'b1, "R6 RST in window");
    ini(F_ACK, 32'd2600, 32'd5600, 16'd600, 1'b0, "R6 entry gone");

    // wrap of sequence space, FIN and linger
    do_reset();
    ini(F_SYN, 32'hFFFF_FF00, 32'd0, 16'd500, 1'b1, "R1 SYN near wrap");
    rsp(F_SYN | F_ACK, 32'd100, 32'hFFFF_FF01, 16'd512, 1'b1, "R3 SYN-ACK wrap");
    ini(F_ACK, 32'hFFFF_FF01, 32'd101, 16'd500, 1'b1, "R4 final ACK wrap");
    ini(F_ACK, 32'h0000_00F0, 32'd101, 16'd500, 1'b1, "R5 accepted across wrap");
    ini(F_ACK, 32'hFFFF_FE00, 32'd101, 16'd500, 1'b0, "R5 stale across wrap");
    ini(F_FIN | F_ACK, 32'h0000_00F0, 32'd101, 16'd500, 1'b1, "R7 first FIN");
    rsp(F_FIN | F_ACK, 32'd100, 32'h0000_00F1, 16'd512, 1'b1, "R7 second FIN");
    ticks(1);
    rsp(F_ACK, 32'd100, 32'h0000_00F1, 16'd512, 1'b1, "R7 alive in linger");
    ticks(1);
    ini(F_ACK, 32'h0000_00F1, 32'd101, 16'd500, 1'b0, "R7 freed after linger");

    // handshake timeout
    do_reset();
    ini(F_SYN, 32'd10, 32'd0, 16'd100, 1'b1, "R8 SYN");
    ticks(2);
    rsp(F_SYN | F_ACK, 32'd70, 32'd11, 16'd100, 1'b1, "R8 alive one tick early");
    ticks(3);
    ini(F_ACK, 32'd11, 32'd71, 16'd100, 1'b0, "R8 half-open expired");
    ini(F_SYN, 32'd10, 32'd0, 16'd100, 1'b1, "R8 slot reusable");

    // idle timeout
    do_reset();
    ini(F_SYN, 32'd10, 32'd0, 16'd100, 1'b1, "R9 SYN");
    rsp(F_SYN | F_ACK, 32'd70, 32'd11, 16'd100, 1'b1, "R9 SYN-ACK");
    ini(F_ACK, 32'd11, 32'd71, 16'd100, 1'b1, "R9 open");
    ticks(4);
    ini(F_ACK, 32'd20, 32'd71, 16'd100, 1'b1, "R9 alive at idle-1");
    ticks(4);
    rsp(F_ACK, 32'd71, 32'd20, 16'd100, 1'b1, "R9 reload kept it");
    ticks(5);
    ini(F_ACK, 32'd20, 32'd71, 16'd100, 1'b0, "R9 idle expired");

    // full table
    do_reset();
    for (int i = 0; i < 16; i++)
      send(IP_A, IP_B, 16'(2000 + i), PT_B, F_SYN, 32'(i), 32'd0, 16'd10, 1'b1, "R2 fill");
    ini(F_SYN, 32'd1, 32'd0, 16'd10, 1'b0, "R2 table full");
    send(IP_B, IP_A, PT_B, 16'd2000, F_SYN | F_ACK, 32'd9, 32'd1, 16'd10, 1'b1,
         "R2 first entry intact");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all verdicts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule